// File: doc/BRIEF.md
# Display Command Stream Decoder

This block sits behind a byte-wide transport and interprets a stream of display commands for a 16-bit-per-pixel framebuffer. Each command is framed by a fixed lead byte (0xAF) followed by an opcode byte and an opcode-dependent argument body. The decoder turns the commands into a register write port, a pixel write port and a copy request port. It also emits a flush pulse. Commands that use run-length or table-compressed pixel data go unparsed to a companion decoder through a pass-through port.

Bytes enter on a valid/ready handshake. The decoder applies back-pressure whenever one of its output ports is still waiting. The pixel and copy ports use valid/ready. Register writes, flush and sync errors are single-cycle pulses. Pixel offsets are 24-bit framebuffer indices, and the decoder increments them for every pixel it emits within a command. Pixel words arrive high byte first.

Top module: `dispcmd_decoder`

## Requirements
- R1: After reset, in_ready is 1, and reg_we, pix_valid, cp_valid, flush_pulse, sync_err and pt_valid are all 0.
- R2: Any byte other than 0xAF that is accepted where a lead byte is expected is dropped. It gives exactly one sync_err pulse and no other output. Decoding resumes at the next 0xAF.
- R3: The bytes 0xAF 0x20 A V give a single one-cycle reg_we pulse with reg_addr=A and reg_data=V. The pulse occurs in the cycle after V is accepted.
- R4: Opcode 0x68 is followed by a 3-byte big-endian offset, a count byte, and then count pixels of two bytes each (high byte first). Pixel k of the command appears on the pixel port with offset base+k, modulo 2^24.
- R5: A count byte of 0 means 256. This applies to the array count, the fill total, the fill chunk count and the copy count.
- R6: Opcode 0x69 is followed by a 3-byte offset and a total count byte, then pairs of a chunk count byte and one 2-byte pixel. Each chunk writes its pixel to consecutive offsets. Chunks continue until the total is covered, and then the command ends.
- R7: A fill chunk whose count exceeds the pixels still owed to the total is clipped to that remainder.
- R8: The bytes 0xAF 0x6A, a 3-byte target, a count byte and a 3-byte source raise cp_valid with cp_dst, cp_count and cp_src. These values are held until cp_ready is seen. in_ready stays 0 while the request is pending.
- R9: 0xAF 0xA0 gives a one-cycle flush_pulse. The pulse comes only after every pixel decoded earlier has been accepted on the pixel port.
- R10: 0xAF 0xAF is a no-op that gives no output, and the next command decodes normally.
- R11: After 0xAF 0x6B or 0xAF 0x78, pt_op shows the opcode. Every following byte is forwarded unchanged on pt_data (pt_valid/pt_ready, with in_ready following pt_ready), including 0xAF bytes, until pt_done is pulsed. After that a lead byte is expected.
- R12: An opcode byte that is not one of 0x20, 0x68, 0x69, 0x6A, 0xA0, 0xAF, 0x6B or 0x78 gives one sync_err pulse and returns the decoder to lead hunting.
- R13: While pix_valid is 1 and pix_ready is 0, pix_valid, pix_offset and pix_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Command byte available |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register address |
| reg_data | output | 8 | Register value |
| pix_valid | output | 1 | Pixel write pending |
| pix_ready | input | 1 | Pixel write accepted |
| pix_offset | output | 24 | Framebuffer pixel index |
| pix_data | output | 16 | Pixel value |
| cp_valid | output | 1 | Copy request pending |
| cp_ready | input | 1 | Copy request accepted |
| cp_dst | output | 24 | Copy target offset |
| cp_src | output | 24 | Copy source offset |
| cp_count | output | 9 | Pixels to copy, 1 to 256 |
| flush_pulse | output | 1 | One-cycle flush after pixel drain |
| sync_err | output | 1 | One-cycle pulse per dropped or unknown byte |
| pt_valid | output | 1 | Forwarded byte valid |
| pt_ready | input | 1 | Companion decoder takes the byte |
| pt_data | output | 8 | Forwarded byte |
| pt_op | output | 8 | Opcode of the forwarded command |
| pt_done | input | 1 | Companion decoder ends the forwarded command |

## Verification
Assertions check the port contracts on every cycle. These are pixel and copy stability under back-pressure, the unit step of pixel offsets inside a run, flush only with an empty pixel stage, no input acceptance while a copy is pending, and fill chunks never exceeding the remainder. Only the bench's scenarios can show the decoded content: that pixel values and offsets match the commands, that 0 counts become 256, that clipping shortens the last chunk, that junk and unknown opcodes resynchronise, and that pass-through bytes reach the companion unchanged.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
  localparam logic [7:0] LEAD_BYTE  = 8'hAF;
  localparam logic [7:0] OP_SETREG  = 8'h20;
  localparam logic [7:0] OP_ARRAY   = 8'h68;
  localparam logic [7:0] OP_FILL    = 8'h69;
  localparam logic [7:0] OP_COPY    = 8'h6A;
  localparam logic [7:0] OP_FLUSH   = 8'hA0;
  localparam logic [7:0] OP_NOP     = 8'hAF;
  localparam logic [7:0] OP_RUNLEN  = 8'h6B;
  localparam logic [7:0] OP_PACKED  = 8'h78;

  localparam int PIX_W = 16;
  localparam int CNT_W = 9;

  typedef enum logic [3:0] {
    ST_LEAD, ST_OP, ST_ARGS, ST_PIX_HI, ST_PIX_LO,
    ST_FILL_CNT, ST_FILL_HI, ST_FILL_LO, ST_COPY, ST_FLUSH, ST_PASS
  } dstate_e;

  function automatic logic [CNT_W-1:0] count_of(input logic [7:0] b);
    return (b == 8'd0) ? CNT_W'(256) : CNT_W'(b);
  endfunction

  function automatic logic [CNT_W-1:0] clip_to(input logic [CNT_W-1:0] want,
                                               input logic [CNT_W-1:0] left);
    return (want > left) ? left : want;
  endfunction
endpackage

// File: rtl/dcd_rst_sync.sv
`timescale 1ns/1ps
module dcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dcd_pixgen.sv
`timescale 1ns/1ps
module dcd_pixgen
  import dcd_pkg::*;
#(
  parameter int OFF_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] ld_off,
  input  logic [PIX_W-1:0] ld_pix,
  input  logic [CNT_W-1:0] ld_n,
  output logic             busy,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [OFF_W-1:0] pix_offset,
  output logic [PIX_W-1:0] pix_data
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             en;

  always_comb begin
    rem_d = rem_q;
    off_d = off_q;
    pix_d = pix_q;
    if (load) begin
      rem_d = ld_n;
      off_d = ld_off;
      pix_d = ld_pix;
    end else if (busy && pix_ready) begin
      rem_d = rem_q - CNT_W'(1);
      off_d = off_q + OFF_W'(1);
    end
  end

  assign busy = (rem_q != '0);
  assign en   = load | (busy & pix_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      off_q <= '0;
      pix_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      off_q <= off_d;
      pix_q <= pix_d;
    end
  end

  assign pix_valid  = busy;
  assign pix_offset = off_q;
  assign pix_data   = pix_q;

  // R13: a stalled pixel holds still
  a_r13_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_offset) && $stable(pix_data)));

  // R4: consecutive pixels of one run step the offset by one
  a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && rem_q > CNT_W'(1)) |=>
      (pix_valid && pix_offset == $past(pix_offset) + OFF_W'(1) && $stable(pix_data)));

  // R9: the parser never overwrites a pending pixel
  a_r9_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/dcd_parser.sv
`timescale 1ns/1ps
module dcd_parser
  import dcd_pkg::*;
#(
  parameter int OFF_W         = 24,
  parameter bit PIX_MSB_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             pix_busy,
  output logic             gen_load,
  output logic [OFF_W-1:0] gen_off,
  output logic [PIX_W-1:0] gen_pix,
  output logic [CNT_W-1:0] gen_n,
  output logic             reg_we,
  output logic [7:0]       reg_addr,
  output logic [7:0]       reg_data,
  output logic             cp_valid,
  input  logic             cp_ready,
  output logic [OFF_W-1:0] cp_dst,
  output logic [OFF_W-1:0] cp_src,
  output logic [CNT_W-1:0] cp_count,
  output logic             flush_pulse,
  output logic             sync_err,
  output logic             pt_valid,
  input  logic             pt_ready,
  output logic [7:0]       pt_data,
  output logic [7:0]       pt_op,
  input  logic             pt_done
);
  localparam int OFF_BYTES = OFF_W / 8;
  localparam int ARG_W     = 2 * OFF_W + 8;
  localparam int HDR_BYTES = OFF_BYTES + 1;
  localparam int CPY_BYTES = 2 * OFF_BYTES + 1;
  localparam int NEED_W    = $clog2(CPY_BYTES + 1);

  dstate_e          state_q, state_d;
  logic [ARG_W-1:0] args_q, args_d;
  logic [NEED_W-1:0] need_q, need_d;
  logic [7:0]       op_q, op_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0] chunk_q, chunk_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [7:0]       hi_q, hi_d;
  logic [7:0]       addr_q, addr_d, val_q, val_d, ptop_q, ptop_d;
  logic             we_q, we_d, flush_q, flush_d, sync_q, sync_d;
  logic             take;
  logic [PIX_W-1:0] pix_word;

  generate
    if (PIX_MSB_FIRST) begin : g_hi_first
      assign pix_word = {hi_q, in_data};
    end else begin : g_lo_first
      assign pix_word = {in_data, hi_q};
    end
  endgenerate

  always_comb begin
    case (state_q)
      ST_LEAD, ST_OP, ST_ARGS, ST_PIX_HI, ST_FILL_CNT, ST_FILL_HI: in_ready = 1'b1;
      ST_PIX_LO, ST_FILL_LO: in_ready = !pix_busy;
      ST_PASS:               in_ready = pt_ready && !pt_done;
      default:               in_ready = 1'b0;
    endcase
  end

  assign take = in_valid && in_ready;

  always_comb begin
    state_d  = state_q;
    args_d   = args_q;
    need_d   = need_q;
    op_d     = op_q;
    left_d   = left_q;
    chunk_d  = chunk_q;
    off_d    = off_q;
    hi_d     = hi_q;
    addr_d   = addr_q;
    val_d    = val_q;
    ptop_d   = ptop_q;
    we_d     = 1'b0;
    flush_d  = 1'b0;
    sync_d   = 1'b0;
    gen_load = 1'b0;
    gen_n    = CNT_W'(1);
    cp_valid = 1'b0;
    pt_valid = 1'b0;
    case (state_q)
      ST_LEAD: if (take) begin
        if (in_data == LEAD_BYTE) state_d = ST_OP;
        else                      sync_d  = 1'b1;
      end
      ST_OP: if (take) begin
        op_d = in_data;
        case (in_data)
          OP_SETREG: begin need_d = NEED_W'(2);         state_d = ST_ARGS; end
          OP_ARRAY, OP_FILL: begin need_d = NEED_W'(HDR_BYTES); state_d = ST_ARGS; end
          OP_COPY:   begin need_d = NEED_W'(CPY_BYTES); state_d = ST_ARGS; end
          OP_FLUSH:  state_d = ST_FLUSH;
          OP_NOP:    state_d = ST_LEAD;
          OP_RUNLEN, OP_PACKED: begin ptop_d = in_data; state_d = ST_PASS; end
          default:   begin sync_d = 1'b1; state_d = ST_LEAD; end
        endcase
      end
      ST_ARGS: if (take) begin
        args_d = {args_q[ARG_W-9:0], in_data};
        need_d = need_q - NEED_W'(1);
        if (need_q == NEED_W'(1)) begin
          case (op_q)
            OP_SETREG: begin
              we_d    = 1'b1;
              addr_d  = args_q[7:0];
              val_d   = in_data;
              state_d = ST_LEAD;
            end
            OP_ARRAY: begin
              off_d   = args_q[OFF_W-1:0];
              left_d  = count_of(in_data);
              state_d = ST_PIX_HI;
            end
            OP_FILL: begin
              off_d   = args_q[OFF_W-1:0];
              left_d  = count_of(in_data);
              state_d = ST_FILL_CNT;
            end
            OP_COPY: state_d = ST_COPY;
            default: state_d = ST_LEAD;
          endcase
        end
      end
      ST_PIX_HI: if (take) begin
        hi_d    = in_data;
        state_d = ST_PIX_LO;
      end
      ST_PIX_LO: if (take) begin
        gen_load = 1'b1;
        off_d    = off_q + OFF_W'(1);
        left_d   = left_q - CNT_W'(1);
        state_d  = (left_q == CNT_W'(1)) ? ST_LEAD : ST_PIX_HI;
      end
      ST_FILL_CNT: if (take) begin
        chunk_d = clip_to(count_of(in_data), left_q);
        state_d = ST_FILL_HI;
      end
      ST_FILL_HI: if (take) begin
        hi_d    = in_data;
        state_d = ST_FILL_LO;
      end
      ST_FILL_LO: if (take) begin
        gen_load = 1'b1;
        gen_n    = chunk_q;
        off_d    = off_q + OFF_W'(chunk_q);
        left_d   = left_q - chunk_q;
        state_d  = (left_q == chunk_q) ? ST_LEAD : ST_FILL_CNT;
      end
      ST_COPY: begin
        cp_valid = 1'b1;
        if (cp_ready) state_d = ST_LEAD;
      end
      ST_FLUSH: if (!pix_busy) begin
        flush_d = 1'b1;
        state_d = ST_LEAD;
      end
      ST_PASS: begin
        pt_valid = in_valid && !pt_done;
        if (pt_done) state_d = ST_LEAD;
      end
      default: state_d = ST_LEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LEAD;
      we_q    <= 1'b0;
      flush_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      flush_q <= flush_d;
      sync_q  <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      args_q  <= '0;
      need_q  <= '0;
      op_q    <= '0;
      left_q  <= '0;
      chunk_q <= '0;
      off_q   <= '0;
      hi_q    <= '0;
      addr_q  <= '0;
      val_q   <= '0;
      ptop_q  <= '0;
    end else if (take) begin
      args_q  <= args_d;
      need_q  <= need_d;
      op_q    <= op_d;
      left_q  <= left_d;
      chunk_q <= chunk_d;
      off_q   <= off_d;
      hi_q    <= hi_d;
      addr_q  <= addr_d;
      val_q   <= val_d;
      ptop_q  <= ptop_d;
    end
  end

  assign gen_off     = off_q;
  assign gen_pix     = pix_word;
  assign reg_we      = we_q;
  assign reg_addr    = addr_q;
  assign reg_data    = val_q;
  assign flush_pulse = flush_q;
  assign sync_err    = sync_q;
  assign pt_data     = in_data;
  assign pt_op       = ptop_q;
  assign cp_dst      = args_q[ARG_W-1 -: OFF_W];
  assign cp_count    = count_of(args_q[OFF_W+7 -: 8]);
  assign cp_src      = args_q[OFF_W-1:0];

  // R3: a register write strobe never lasts two cycles
  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8: a pending copy holds its fields and blocks the input
  a_r8_copy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_ready) |=>
      (cp_valid && $stable(cp_dst) && $stable(cp_src) && $stable(cp_count)));
  a_r8_copy_block: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> !in_ready);

  // R7: a chunk in flight never exceeds what the total still owes
  a_r7_chunk_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL_HI || state_q == ST_FILL_LO) |->
      (chunk_q != '0 && chunk_q <= left_q));

  // R2: a sync error comes alone
  a_r2_sync_alone: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (!reg_we && !flush_pulse));
endmodule

// File: rtl/dispcmd_decoder.sv
`timescale 1ns/1ps
module dispcmd_decoder
  import dcd_pkg::*;
#(
  parameter int OFF_W         = 24,
  parameter bit PIX_MSB_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             reg_we,
  output logic [7:0]       reg_addr,
  output logic [7:0]       reg_data,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [OFF_W-1:0] pix_offset,
  output logic [PIX_W-1:0] pix_data,
  output logic             cp_valid,
  input  logic             cp_ready,
  output logic [OFF_W-1:0] cp_dst,
  output logic [OFF_W-1:0] cp_src,
  output logic [CNT_W-1:0] cp_count,
  output logic             flush_pulse,
  output logic             sync_err,
  output logic             pt_valid,
  input  logic             pt_ready,
  output logic [7:0]       pt_data,
  output logic [7:0]       pt_op,
  input  logic             pt_done
);
  logic             rst_n_s;
  logic             pix_busy;
  logic             gen_load;
  logic [OFF_W-1:0] gen_off;
  logic [PIX_W-1:0] gen_pix;
  logic [CNT_W-1:0] gen_n;

  dcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dcd_parser #(.OFF_W(OFF_W), .PIX_MSB_FIRST(PIX_MSB_FIRST)) u_parse (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .pix_busy    (pix_busy),
    .gen_load    (gen_load),
    .gen_off     (gen_off),
    .gen_pix     (gen_pix),
    .gen_n       (gen_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_data    (reg_data),
    .cp_valid    (cp_valid),
    .cp_ready    (cp_ready),
    .cp_dst      (cp_dst),
    .cp_src      (cp_src),
    .cp_count    (cp_count),
    .flush_pulse (flush_pulse),
    .sync_err    (sync_err),
    .pt_valid    (pt_valid),
    .pt_ready    (pt_ready),
    .pt_data     (pt_data),
    .pt_op       (pt_op),
    .pt_done     (pt_done)
  );

  dcd_pixgen #(.OFF_W(OFF_W)) u_pix (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (gen_load),
    .ld_off     (gen_off),
    .ld_pix     (gen_pix),
    .ld_n       (gen_n),
    .busy       (pix_busy),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_offset (pix_offset),
    .pix_data   (pix_data)
  );

  // R9: flush is only signalled once the pixel stage is empty
  a_r9_flush_drained: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_pulse |-> !pix_valid);

  // R11: forwarding and copy requests never overlap
  a_r11_pass_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    pt_valid |-> (!cp_valid && !reg_we));
endmodule

// File: tb/dispcmd_decoder_test.sv
`timescale 1ns/1ps
module dispcmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [7:0]  in_data;
  logic        reg_we;
  logic [7:0]  reg_addr, reg_data;
  logic        pix_valid, pix_ready;
  logic [23:0] pix_offset;
  logic [15:0] pix_data;
  logic        cp_valid, cp_ready;
  logic [23:0] cp_dst, cp_src;
  logic [8:0]  cp_count;
  logic        flush_pulse, sync_err;
  logic        pt_valid, pt_ready, pt_done;
  logic [7:0]  pt_data, pt_op;

  always #4 clk = ~clk;

  dispcmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_offset(pix_offset), .pix_data(pix_data),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_dst(cp_dst), .cp_src(cp_src), .cp_count(cp_count),
    .flush_pulse(flush_pulse), .sync_err(sync_err),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_data(pt_data), .pt_op(pt_op), .pt_done(pt_done)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0]  inq[$];
  logic [39:0] exp_pix[$], got_pix[$];
  logic [15:0] exp_reg[$], got_reg[$], exp_pt[$], got_pt[$];
  logic [56:0] exp_cp[$], got_cp[$];
  int          exp_fl[$], got_fl[$];
  int          exp_sync = 0, got_sync = 0, pix_seen = 0;
  int          pt_left = 0;
  bit          pt_armed = 1'b0;
  logic [23:0] fl_off;
  int          fl_left;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // one process drives inputs after each falling edge and samples handshakes
  initial begin
    in_valid = 1'b0; in_data = 8'h00; pix_ready = 1'b0; cp_ready = 1'b0;
    pt_ready = 1'b0; pt_done = 1'b0;
    forever begin
      @(negedge clk);
      pix_ready = ($urandom % 4) != 0;
      cp_ready  = ($urandom % 3) == 0;
      pt_ready  = ($urandom % 2) == 0;
      if (pt_armed && pt_left == 0) begin pt_done = 1'b1; pt_armed = 1'b0; end
      else pt_done = 1'b0;
      in_valid = (inq.size() > 0) && (($urandom % 5) != 0);
      in_data  = (inq.size() > 0) ? inq[0] : 8'h00;
      #1;
      if (rst_n) begin
        if (pix_valid && pix_ready) begin got_pix.push_back({pix_offset, pix_data}); pix_seen++; end
        if (reg_we) got_reg.push_back({reg_addr, reg_data});
        if (cp_valid && cp_ready) got_cp.push_back({cp_dst, cp_count, cp_src});
        if (cp_valid && in_ready) chk(1'b0, "R8", "input open during copy", 1, 0);
        if (flush_pulse) got_fl.push_back(pix_seen);
        if (sync_err) got_sync++;
        if (pt_valid && pt_ready) begin got_pt.push_back({pt_op, pt_data}); pt_left--; end
        if (in_valid && in_ready) void'(inq.pop_front());
      end
    end
  end

  function automatic logic [7:0] cbyte(input int n);
    return (n == 256) ? 8'h00 : n[7:0];
  endfunction

  task automatic put3(input logic [23:0] v);
    inq.push_back(v[23:16]); inq.push_back(v[15:8]); inq.push_back(v[7:0]);
  endtask

  task automatic cmd_setreg(input logic [7:0] a, input logic [7:0] v);
    inq.push_back(8'hAF); inq.push_back(8'h20); inq.push_back(a); inq.push_back(v);
    exp_reg.push_back({a, v});
  endtask

  task automatic cmd_array(input logic [23:0] off, input int n);
    inq.push_back(8'hAF); inq.push_back(8'h68); put3(off); inq.push_back(cbyte(n));
    for (int k = 0; k < n; k++) begin
      logic [15:0] p;
      p = 16'($urandom);
      inq.push_back(p[15:8]); inq.push_back(p[7:0]);
      exp_pix.push_back({off + 24'(k), p});
    end
  endtask

  task automatic cmd_fill_hdr(input logic [23:0] off, input int total);
    inq.push_back(8'hAF); inq.push_back(8'h69); put3(off); inq.push_back(cbyte(total));
    fl_off = off; fl_left = total;
  endtask

  task automatic fill_chunk(input int c, input logic [15:0] p);
    int n;
    n = (c > fl_left) ? fl_left : c;
    inq.push_back(cbyte(c)); inq.push_back(p[15:8]); inq.push_back(p[7:0]);
    for (int k = 0; k < n; k++) exp_pix.push_back({fl_off + 24'(k), p});
    fl_off = fl_off + 24'(n); fl_left = fl_left - n;
  endtask

  task automatic cmd_copy(input logic [23:0] dst, input int n, input logic [23:0] src);
    inq.push_back(8'hAF); inq.push_back(8'h6A); put3(dst); inq.push_back(cbyte(n)); put3(src);
    exp_cp.push_back({dst, 9'(n), src});
  endtask

  task automatic cmd_flush();
    inq.push_back(8'hAF); inq.push_back(8'hA0);
    exp_fl.push_back(exp_pix.size());
  endtask

  task automatic cmd_pass(input logic [7:0] op, input int len);
    inq.push_back(8'hAF); inq.push_back(op);
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = (k % 3 == 0) ? 8'hAF : 8'($urandom);
      inq.push_back(b); exp_pt.push_back({op, b});
    end
    pt_left = len; pt_armed = 1'b1;
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 8) begin
      @(negedge clk);
      if (inq.size() == 0 && !pix_valid && !cp_valid && !pt_armed) idle++;
      else idle = 0;
    end
  endtask

  task automatic end_phase(input string req);
    drain();
    chk(got_pix.size() == exp_pix.size(), req, "pixel count", got_pix.size(), exp_pix.size());
    foreach (exp_pix[i]) if (i < got_pix.size())
      chk(got_pix[i] == exp_pix[i], req, "pixel offset/data", got_pix[i], exp_pix[i]);
    chk(got_reg.size() == exp_reg.size(), req, "regwrite count", got_reg.size(), exp_reg.size());
    foreach (exp_reg[i]) if (i < got_reg.size())
      chk(got_reg[i] == exp_reg[i], req, "regwrite addr/data", got_reg[i], exp_reg[i]);
    chk(got_cp.size() == exp_cp.size(), req, "copy count", got_cp.size(), exp_cp.size());
    foreach (exp_cp[i]) if (i < got_cp.size())
      chk(got_cp[i] == exp_cp[i], req, "copy fields", got_cp[i], exp_cp[i]);
    chk(got_fl.size() == exp_fl.size(), req, "flush count", got_fl.size(), exp_fl.size());
    foreach (exp_fl[i]) if (i < got_fl.size())
      chk(got_fl[i] == exp_fl[i], req, "pixels done at flush", got_fl[i], exp_fl[i]);
    chk(got_pt.size() == exp_pt.size(), req, "forwarded count", got_pt.size(), exp_pt.size());
    foreach (exp_pt[i]) if (i < got_pt.size())
      chk(got_pt[i] == exp_pt[i], req, "forwarded op/byte", got_pt[i], exp_pt[i]);
    chk(got_sync == exp_sync, req, "sync errors", got_sync, exp_sync);
    exp_pix.delete(); got_pix.delete(); exp_reg.delete(); got_reg.delete();
    exp_cp.delete(); got_cp.delete(); exp_fl.delete(); got_fl.delete();
    exp_pt.delete(); got_pt.delete(); exp_sync = 0; got_sync = 0; pix_seen = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    chk(in_ready === 1'b1, "R1", "in_ready", in_ready, 1);
    chk({reg_we, pix_valid, cp_valid, flush_pulse, sync_err, pt_valid} === 6'b0,
        "R1", "strobes", {reg_we, pix_valid, cp_valid, flush_pulse, sync_err, pt_valid}, 0);

    // R3: register writes, directed then random
    cmd_setreg(8'h00, 8'h01);
    cmd_setreg(8'hFF, 8'hAF);
    for (int i = 0; i < 6; i++) cmd_setreg(8'($urandom), 8'($urandom));
    end_phase("R3");

    // R4: pixel arrays, including an offset that wraps
    cmd_array(24'h000010, 3);
    cmd_array(24'hFFFFFE, 4);
    for (int i = 0; i < 5; i++) cmd_array(24'($urandom), 1 + ($urandom % 40));
    end_phase("R4");

    // R5: zero count bytes mean 256
    cmd_array(24'h001000, 256);
    cmd_fill_hdr(24'h200000, 256);
    fill_chunk(256, 16'hBEEF);
    cmd_copy(24'h000100, 256, 24'h000900);
    end_phase("R5");

    // R6: fills covering the total exactly
    cmd_fill_hdr(24'h000040, 10);
    fill_chunk(4, 16'h1234); fill_chunk(1, 16'hAFAF); fill_chunk(5, 16'h00FF);
    for (int i = 0; i < 4; i++) begin
      cmd_fill_hdr(24'($urandom), 1 + ($urandom % 120));
      while (fl_left > 0) fill_chunk(1 + ($urandom % (fl_left < 30 ? fl_left : 30)), 16'($urandom));
    end
    cmd_setreg(8'h1F, 8'h00);
    end_phase("R6");

    // R7: chunks past the total are clipped
    cmd_fill_hdr(24'h000500, 5);
    fill_chunk(3, 16'hA5A5); fill_chunk(4, 16'h5A5A);
    cmd_fill_hdr(24'h000600, 2);
    fill_chunk(256, 16'h0F0F);
    for (int i = 0; i < 3; i++) begin
      cmd_fill_hdr(24'($urandom), 1 + ($urandom % 60));
      while (fl_left > 0) fill_chunk(1 + ($urandom % 50), 16'($urandom));
    end
    cmd_setreg(8'h26, 8'h77);
    end_phase("R7");

    // R8: copy requests with stalls
    cmd_copy(24'h123456, 7, 24'hABCDEF);
    for (int i = 0; i < 4; i++) cmd_copy(24'($urandom), 1 + ($urandom % 256), 24'($urandom));
    end_phase("R8");

    // R9: flush waits for earlier pixels
    cmd_fill_hdr(24'h000000, 200);
    fill_chunk(200, 16'h7777);
    cmd_flush();
    cmd_array(24'h000300, 2);
    cmd_flush();
    end_phase("R9");

    // R10: no-op produces nothing
    inq.push_back(8'hAF); inq.push_back(8'hAF);
    cmd_setreg(8'h05, 8'h06);
    inq.push_back(8'hAF); inq.push_back(8'hAF);
    end_phase("R10");

    // R2: junk before a lead byte is dropped, one error each
    inq.push_back(8'h12); inq.push_back(8'h00); inq.push_back(8'h20); exp_sync += 3;
    cmd_setreg(8'h0A, 8'h0B);
    inq.push_back(8'hFF); exp_sync += 1;
    cmd_array(24'h000020, 1);
    end_phase("R2");

    // R12: unknown opcode resynchronises
    inq.push_back(8'hAF); inq.push_back(8'h55); exp_sync += 1;
    cmd_setreg(8'h30, 8'h31);
    inq.push_back(8'hAF); inq.push_back(8'h60); exp_sync += 1;
    cmd_copy(24'h000001, 1, 24'h000002);
    end_phase("R12");

    // R11: compressed commands pass through unchanged
    cmd_pass(8'h6B, 9);
    end_phase("R11");
    cmd_pass(8'h78, 5);
    end_phase("R11");
    cmd_setreg(8'h40, 8'h41);
    end_phase("R11");

    // R13: random mix under back-pressure
    for (int i = 0; i < 12; i++) begin
      case ($urandom % 4)
        0: cmd_setreg(8'($urandom), 8'($urandom));
        1: cmd_array(24'($urandom), 1 + ($urandom % 20));
        2: begin
          cmd_fill_hdr(24'($urandom), 1 + ($urandom % 50));
          while (fl_left > 0) fill_chunk(1 + ($urandom % 40), 16'($urandom));
        end
        default: cmd_copy(24'($urandom), 1 + ($urandom % 256), 24'($urandom));
      endcase
    end
    cmd_flush();
    end_phase("R13");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule